// File: doc/BRIEF.md
# Configurable Logic Element Array

This block is a small programmable logic fabric made of 32 logic elements, arranged as four groups of eight. Each element picks two operand bits through two source selectors. Each selector can take a sibling element of the same group, one of 14 external input pins, or a constant zero. The element combines the two bits through a 4-entry truth table. Its result is either passed straight through or captured in a flip-flop. That flip-flop is clocked by the system clock and gated by an enable that each group chooses for itself.

The four groups are closed into a ring. The last element of each group can drive the first selector of the first element of the following group, and group 3 wraps back to group 0. Element results leave the fabric in three ways. Software can read them as two 16-bit data words. Each of 13 output pins can take any element. Each of four level-sensitive interrupt lines can also take any element. Inverted or edge-triggered interrupts are not built in. They are composed from extra elements, for example a registered delay element and a combinational element that ANDs the live signal with the inverse of the delayed copy.

All settings live in a word-addressed register file with a synchronous write port and a combinational read port. Reset clears every setting, so all element outputs, pins and interrupts start low.

Top module: `lgc_fabric`

## Requirements
- R1: After reset, every output pin, every interrupt line, every configuration word and both data words read as zero.
- R2: An element's function result is bit {op1,op0} of its 4-bit truth table (element word bits 13:10), where op0 and op1 are the outputs of its first and second selector. With the bypass bit (bit 14) set, this result appears at the element output in the same cycle.
- R3: A selector code (element word bits 4:0 for the first selector, bits 9:5 for the second) of 0 to 7 takes that element of the same group. A code of 8 to 21 takes input pin code-8. A code of 22 to 31 takes constant 0.
- R4: With the bypass bit clear, the element output changes only after a rising clock edge at which its group's enable is active, and it then holds the function result of that edge.
- R5: Group clock source word (address 32+group, bits 1:0): 0 enables every cycle, 1 enables once every DIV_RATIO cycles, 2 enables while input pin CLK_PIN_A (12) is high, 3 enables while input pin CLK_PIN_B (13) is high.
- R6: For the first element of each group, first-selector code 0 takes the last element of the previous group, and group 0 takes element 31. Code 0 in any other position takes local element 0.
- R7: Output pin p (address 36+p) is driven by element bits 4:0 when bit 5 is set, and is 0 when bit 5 is clear.
- R8: Interrupt i (address 49+i) is high exactly while bit 5 is set and the element named by bits 4:0 is high. Clearing bit 5 drops it at once.
- R9: Address 53 reads element outputs 15:0 and address 54 reads element outputs 31:16.
- R10: Configuration words read back as written, with unused bits as 0. Writes to the data words or to unmapped addresses change nothing, and unmapped addresses read 0.
- R11: A registered delay element followed by a bypassed element with truth table 4'b0010 (op0 AND NOT op1) raises its interrupt for exactly one cycle on a rising input. A falling input gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Write word address |
| cfg_wdata | input | 16 | Write data |
| cfg_raddr | input | 6 | Read word address |
| cfg_rdata | output | 16 | Read data, combinational |
| pin_in | input | 14 | External fabric inputs |
| pin_out | output | 13 | Fabric output pins |
| irq | output | 4 | Level interrupt requests |

## Verification
The bench walks truth tables through a vector table. It then targets the selector encoding at its edges: code 0 at a group's first element versus elsewhere, the last pin code 21, and the first constant code 22. A design that decodes code 0 without the ring exception, or that is off by one at the pin boundary, drives the wrong pin level. The divided enable is timed by measuring the spacing between two captured changes, which exposes a wrong divider period. The pin-gated enable is held low while the data input toggles, which catches a flip-flop that ignores its group enable. The edge detector must pulse high for exactly one cycle, so an interrupt that is registered, or a delay element that is combinational, shows as a missing or stretched pulse.

// File: rtl/lgc_pkg.sv
package lgc_pkg;
    localparam int N_BLK      = 4;
    localparam int BLK_SZ     = 8;
    localparam int N_ELEM     = N_BLK * BLK_SZ;
    localparam int N_PIN_IN   = 14;
    localparam int N_PIN_OUT  = 13;
    localparam int N_IRQ      = 4;
    localparam int SEL_W      = 5;
    localparam int LUT_W      = 4;
    localparam int IDX_W      = $clog2(N_ELEM);
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 16;
    localparam int SEL_PIN_LO = BLK_SZ;
    localparam int SEL_ZERO   = BLK_SZ + N_PIN_IN;

    localparam int A_ELEM     = 0;
    localparam int A_CLK      = A_ELEM + N_ELEM;
    localparam int A_PIN      = A_CLK + N_BLK;
    localparam int A_IRQ      = A_PIN + N_PIN_OUT;
    localparam int A_DOUT_LO  = A_IRQ + N_IRQ;
    localparam int A_DOUT_HI  = A_DOUT_LO + 1;

    typedef struct packed {
        logic               bypass;
        logic [LUT_W-1:0]   lut;
        logic [SEL_W-1:0]   sel1;
        logic [SEL_W-1:0]   sel0;
    } elem_cfg_t;

    typedef struct packed {
        logic               en;
        logic [IDX_W-1:0]   idx;
    } tap_cfg_t;

    typedef enum logic [1:0] {
        SRC_SYS   = 2'd0,
        SRC_DIV   = 2'd1,
        SRC_PIN_A = 2'd2,
        SRC_PIN_B = 2'd3
    } clk_src_e;

    localparam int ELEM_CFG_W = $bits(elem_cfg_t);
    localparam int TAP_W      = $bits(tap_cfg_t);

    // Operand selection for one selector of one element
    function automatic logic pick_src(
        input logic [SEL_W-1:0]    sel,
        input logic                ring_slot,
        input logic [BLK_SZ-1:0]   local_q,
        input logic                ring_q,
        input logic [N_PIN_IN-1:0] pins
    );
        logic r;
        if (int'(sel) < SEL_PIN_LO) begin
            if (ring_slot && sel == '0) r = ring_q;
            else                        r = local_q[sel[$clog2(BLK_SZ)-1:0]];
        end else if (int'(sel) < SEL_ZERO) begin
            r = pins[sel - SEL_W'(SEL_PIN_LO)];
        end else begin
            r = 1'b0;
        end
        return r;
    endfunction
endpackage

// File: rtl/lgc_cfg_regs.sv
module lgc_cfg_regs
    import lgc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      waddr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [ADDR_W-1:0]      raddr,
    input  logic [N_ELEM-1:0]      dout,
    output logic [DATA_W-1:0]      rdata,
    output elem_cfg_t              elem_cfg [N_ELEM],
    output clk_src_e               clk_sel  [N_BLK],
    output tap_cfg_t               pin_cfg  [N_PIN_OUT],
    output tap_cfg_t               irq_cfg  [N_IRQ]
);
    logic unused_wbits;
    assign unused_wbits = ^wdata[DATA_W-1:ELEM_CFG_W];

    // Write side: one decoder per register group
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ELEM; i++)    elem_cfg[i] <= '0;
            for (int i = 0; i < N_BLK; i++)     clk_sel[i]  <= SRC_SYS;
            for (int i = 0; i < N_PIN_OUT; i++) pin_cfg[i]  <= '0;
            for (int i = 0; i < N_IRQ; i++)     irq_cfg[i]  <= '0;
        end else if (we) begin
            for (int i = 0; i < N_ELEM; i++)
                if (waddr == ADDR_W'(A_ELEM + i))
                    elem_cfg[i] <= elem_cfg_t'(wdata[ELEM_CFG_W-1:0]);
            for (int i = 0; i < N_BLK; i++)
                if (waddr == ADDR_W'(A_CLK + i))
                    clk_sel[i] <= clk_src_e'(wdata[1:0]);
            for (int i = 0; i < N_PIN_OUT; i++)
                if (waddr == ADDR_W'(A_PIN + i))
                    pin_cfg[i] <= tap_cfg_t'(wdata[TAP_W-1:0]);
            for (int i = 0; i < N_IRQ; i++)
                if (waddr == ADDR_W'(A_IRQ + i))
                    irq_cfg[i] <= tap_cfg_t'(wdata[TAP_W-1:0]);
        end
    end

    // Read side: combinational, zero for unmapped words
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_ELEM; i++)
            if (raddr == ADDR_W'(A_ELEM + i)) rdata = DATA_W'(elem_cfg[i]);
        for (int i = 0; i < N_BLK; i++)
            if (raddr == ADDR_W'(A_CLK + i)) rdata = DATA_W'(clk_sel[i]);
        for (int i = 0; i < N_PIN_OUT; i++)
            if (raddr == ADDR_W'(A_PIN + i)) rdata = DATA_W'(pin_cfg[i]);
        for (int i = 0; i < N_IRQ; i++)
            if (raddr == ADDR_W'(A_IRQ + i)) rdata = DATA_W'(irq_cfg[i]);
        if (raddr == ADDR_W'(A_DOUT_LO)) rdata = dout[DATA_W-1:0];
        if (raddr == ADDR_W'(A_DOUT_HI)) rdata = dout[N_ELEM-1:DATA_W];
    end
endmodule

// File: rtl/lgc_clk_en.sv
module lgc_clk_en
    import lgc_pkg::*;
#(
    parameter int DIV_RATIO = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  clk_src_e        clk_sel [N_BLK],
    input  logic            pin_a,
    input  logic            pin_b,
    output logic [N_BLK-1:0] blk_ce,
    output logic            div_tick
);
    localparam int CNT_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_RATIO - 1);

    logic [CNT_W-1:0] div_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                div_cnt <= '0;
        else if (div_cnt == CNT_LAST) div_cnt <= '0;
        else                       div_cnt <= div_cnt + 1'b1;
    end

    assign div_tick = (div_cnt == CNT_LAST);

    always_comb begin
        for (int b = 0; b < N_BLK; b++) begin
            unique case (clk_sel[b])
                SRC_SYS:   blk_ce[b] = 1'b1;
                SRC_DIV:   blk_ce[b] = div_tick;
                SRC_PIN_A: blk_ce[b] = pin_a;
                SRC_PIN_B: blk_ce[b] = pin_b;
            endcase
        end
    end
endmodule

// File: rtl/lgc_block.sv
module lgc_block
    import lgc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce,
    input  elem_cfg_t           cfg [BLK_SZ],
    input  logic [N_PIN_IN-1:0] pin_in,
    input  logic                ring_in,
    output logic [BLK_SZ-1:0]   q_out
);
    for (genvar j = 0; j < BLK_SZ; j++) begin : g_elem
        logic op0, op1, fn, q;

        always_comb begin
            op0 = pick_src(cfg[j].sel0, (j == 0), q_out, ring_in, pin_in);
            op1 = pick_src(cfg[j].sel1, 1'b0,     q_out, ring_in, pin_in);
            fn  = cfg[j].lut[{op1, op0}];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  q <= 1'b0;
            else if (ce) q <= fn;
        end

        assign q_out[j] = cfg[j].bypass ? fn : q;
    end
endmodule

// File: rtl/lgc_route.sv
module lgc_route
    import lgc_pkg::*;
(
    input  logic [N_ELEM-1:0]    dout,
    input  tap_cfg_t             pin_cfg [N_PIN_OUT],
    input  tap_cfg_t             irq_cfg [N_IRQ],
    output logic [N_PIN_OUT-1:0] pin_out,
    output logic [N_IRQ-1:0]     irq
);
    for (genvar p = 0; p < N_PIN_OUT; p++) begin : g_pin
        assign pin_out[p] = pin_cfg[p].en & dout[pin_cfg[p].idx];
    end
    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
        assign irq[i] = irq_cfg[i].en & dout[irq_cfg[i].idx];
    end
endmodule

// File: rtl/lgc_fabric.sv
module lgc_fabric
    import lgc_pkg::*;
#(
    parameter int DIV_RATIO = 4,
    parameter int CLK_PIN_A = 12,
    parameter int CLK_PIN_B = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic [ADDR_W-1:0]    cfg_raddr,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  logic [N_PIN_IN-1:0]  pin_in,
    output logic [N_PIN_OUT-1:0] pin_out,
    output logic [N_IRQ-1:0]     irq
);
    elem_cfg_t          elem_cfg [N_ELEM];
    clk_src_e           clk_sel  [N_BLK];
    tap_cfg_t           pin_cfg  [N_PIN_OUT];
    tap_cfg_t           irq_cfg  [N_IRQ];
    logic [N_ELEM-1:0]  elem_out;
    logic [N_BLK-1:0]   blk_ce;
    logic               div_tick;

    lgc_cfg_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .waddr    (cfg_addr),
        .wdata    (cfg_wdata),
        .raddr    (cfg_raddr),
        .dout     (elem_out),
        .rdata    (cfg_rdata),
        .elem_cfg (elem_cfg),
        .clk_sel  (clk_sel),
        .pin_cfg  (pin_cfg),
        .irq_cfg  (irq_cfg)
    );

    lgc_clk_en #(.DIV_RATIO(DIV_RATIO)) u_clk_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_sel  (clk_sel),
        .pin_a    (pin_in[CLK_PIN_A]),
        .pin_b    (pin_in[CLK_PIN_B]),
        .blk_ce   (blk_ce),
        .div_tick (div_tick)
    );

    for (genvar b = 0; b < N_BLK; b++) begin : g_blk
        localparam int PREV = (b + N_BLK - 1) % N_BLK;
        elem_cfg_t blk_cfg [BLK_SZ];

        always_comb
            for (int j = 0; j < BLK_SZ; j++) blk_cfg[j] = elem_cfg[b*BLK_SZ + j];

        lgc_block u_block (
            .clk     (clk),
            .rst_n   (rst_n),
            .ce      (blk_ce[b]),
            .cfg     (blk_cfg),
            .pin_in  (pin_in),
            .ring_in (elem_out[PREV*BLK_SZ + BLK_SZ - 1]),
            .q_out   (elem_out[b*BLK_SZ +: BLK_SZ])
        );
    end

    lgc_route u_route (
        .dout    (elem_out),
        .pin_cfg (pin_cfg),
        .irq_cfg (irq_cfg),
        .pin_out (pin_out),
        .irq     (irq)
    );
endmodule

// File: rtl/lgc_fabric_chk.sv
module lgc_fabric_chk
    import lgc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic [N_PIN_OUT-1:0] pin_out,
    input logic [N_IRQ-1:0]     irq,
    input logic [N_ELEM-1:0]    dout,
    input elem_cfg_t            elem_cfg [N_ELEM],
    input tap_cfg_t             pin_cfg  [N_PIN_OUT],
    input tap_cfg_t             irq_cfg  [N_IRQ],
    input logic [N_BLK-1:0]     blk_ce,
    input logic                 div_tick
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq == '0 && pin_out == '0)); // R1

    AST_DIV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |=> !div_tick); // R5

    for (genvar e = 0; e < N_ELEM; e++) begin : g_e
        AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (!blk_ce[e / BLK_SZ] && !elem_cfg[e].bypass && !cfg_we)
            |=> $stable(dout[e])); // R4
        AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_we |=> $stable(elem_cfg[e])); // R10
    end

    for (genvar p = 0; p < N_PIN_OUT; p++) begin : g_p
        AST_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_cfg[p].en |-> !pin_out[p]); // R7
    end

    for (genvar i = 0; i < N_IRQ; i++) begin : g_i
        AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_cfg[i].en |-> !irq[i]); // R8
        AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            ($stable(irq_cfg[i]) && $stable(dout)) |-> $stable(irq[i])); // R8
    end
endmodule

bind lgc_fabric lgc_fabric_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .pin_out  (pin_out),
    .irq      (irq),
    .dout     (elem_out),
    .elem_cfg (elem_cfg),
    .pin_cfg  (pin_cfg),
    .irq_cfg  (irq_cfg),
    .blk_ce   (blk_ce),
    .div_tick (div_tick)
);

// File: tb/lgc_fabric_bench.sv
module lgc_fabric_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [5:0]  cfg_raddr = '0;
    logic [15:0] cfg_rdata;
    logic [13:0] pin_in = '0;
    logic [12:0] pin_out;
    logic [3:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lgc_fabric u_lgc_fabric (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
    );

    // {lut[3:0], op0, op1, expected}
    localparam logic [6:0] VEC [8] = '{
        {4'b1000, 1'b1, 1'b1, 1'b1}, {4'b1000, 1'b1, 1'b0, 1'b0},
        {4'b1110, 1'b0, 1'b0, 1'b0}, {4'b1110, 1'b0, 1'b1, 1'b1},
        {4'b0110, 1'b1, 1'b1, 1'b0}, {4'b0110, 1'b1, 1'b0, 1'b1},
        {4'b0111, 1'b1, 1'b1, 1'b0}, {4'b0111, 1'b0, 1'b0, 1'b1}
    };

    function automatic logic [15:0] ecfg(input logic byp, input logic [3:0] lut,
                                         input logic [4:0] s1, input logic [4:0] s0);
        return {1'b0, byp, lut, s1, s0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        cfg_raddr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic [15:0] rv;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 pin_out", 32'(pin_out), 0);
        check("R1 irq", 32'(irq), 0);
        rd(6'd0, rv);  check("R1 elem cfg", 32'(rv), 0);
        rd(6'd36, rv); check("R1 pin cfg", 32'(rv), 0);
        rd(6'd53, rv); check("R1 dout lo", 32'(rv), 0);
        rd(6'd54, rv); check("R1 dout hi", 32'(rv), 0);

        // R2: truth table walk, element 1 bypassed, op0=pin0, op1=pin1
        wr(6'd36, 16'h0021);
        for (int k = 0; k < 8; k++) begin
            wr(6'd1, ecfg(1'b1, VEC[k][6:3], 5'd9, 5'd8));
            pin_in[0] = VEC[k][2];
            pin_in[1] = VEC[k][1];
            #1 check($sformatf("R2 vec%0d", k), 32'(pin_out[0]), 32'(VEC[k][0]));
        end

        // R3: local element, last pin, constant codes
        wr(6'd1, ecfg(1'b1, 4'b1010, 5'd0, 5'd8));
        wr(6'd2, ecfg(1'b1, 4'b1010, 5'd0, 5'd1));
        wr(6'd37, 16'h0022);
        pin_in[0] = 1'b1;
        #1 check("R3 local code1 high", 32'(pin_out[1]), 1);
        pin_in[0] = 1'b0;
        #1 check("R3 local code1 low", 32'(pin_out[1]), 0);
        wr(6'd2, ecfg(1'b1, 4'b1010, 5'd0, 5'd21));
        pin_in[13] = 1'b1;
        #1 check("R3 code21 pin13", 32'(pin_out[1]), 1);
        pin_in[13] = 1'b0;
        wr(6'd2, ecfg(1'b1, 4'b0101, 5'd0, 5'd22));
        #1 check("R3 code22 zero inverted", 32'(pin_out[1]), 1);
        wr(6'd2, ecfg(1'b1, 4'b1010, 5'd0, 5'd22));
        #1 check("R3 code22 zero", 32'(pin_out[1]), 0);

        // R4: registered element 3 buffers pin2
        wr(6'd3, ecfg(1'b0, 4'b1010, 5'd0, 5'd10));
        wr(6'd38, 16'h0023);
        pin_in[2] = 1'b1;
        #1 check("R4 before edge", 32'(pin_out[2]), 0);
        @(posedge clk); #1 check("R4 after edge", 32'(pin_out[2]), 1);

        // R5: divided enable spacing
        wr(6'd32, 16'd1);
        pin_in[2] = 1'b0;
        n = 0;
        while (pin_out[2] !== 1'b0 && n < 20) begin @(negedge clk); n++; end
        check("R5 divided fall", 32'(pin_out[2]), 0);
        pin_in[2] = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (pin_out[2] !== 1'b1 && n < 20);
        check("R5 divided spacing", 32'(n), 4);

        // R5: pin A gated enable
        wr(6'd32, 16'd2);
        pin_in[12] = 1'b0;
        pin_in[2] = 1'b0;
        repeat (3) @(negedge clk);
        #1 check("R5 pinA low holds", 32'(pin_out[2]), 1);
        pin_in[12] = 1'b1;
        @(negedge clk); #1 check("R5 pinA high captures", 32'(pin_out[2]), 0);
        pin_in[12] = 1'b0;
        wr(6'd32, 16'd0);

        // R6: ring links 31->0 and 7->8
        wr(6'd31, ecfg(1'b1, 4'b1010, 5'd0, 5'd11));
        wr(6'd0,  ecfg(1'b1, 4'b1010, 5'd0, 5'd0));
        wr(6'd7,  ecfg(1'b1, 4'b1010, 5'd0, 5'd11));
        wr(6'd8,  ecfg(1'b1, 4'b0101, 5'd0, 5'd0));
        wr(6'd39, 16'h0020);
        wr(6'd40, 16'h0028);
        pin_in[3] = 1'b1;
        #1 check("R6 wrap 31 to 0", 32'(pin_out[3]), 1);
        check("R6 link 7 to 8", 32'(pin_out[4]), 0);
        pin_in[3] = 1'b0;
        #1 check("R6 wrap 31 to 0 low", 32'(pin_out[3]), 0);
        check("R6 link 7 to 8 low", 32'(pin_out[4]), 1);

        // R7: disabled output pin
        pin_in[3] = 1'b1;
        wr(6'd39, 16'h0000);
        #1 check("R7 disabled pin", 32'(pin_out[3]), 0);

        // R9: data words (elements 0, 7, 31 high)
        wr(6'd3, 16'h0000);
        repeat (2) @(negedge clk);
        rd(6'd53, rv); check("R9 dout lo", 32'(rv), 32'h0081);
        rd(6'd54, rv); check("R9 dout hi", 32'(rv), 32'h8000);

        // R10: readback and ignored writes
        wr(6'd20, 16'hDA5A);
        rd(6'd20, rv); check("R10 elem readback", 32'(rv), 32'h5A5A);
        wr(6'd33, 16'hFFFF);
        rd(6'd33, rv); check("R10 clk readback", 32'(rv), 32'h0003);
        wr(6'd33, 16'h0000);
        wr(6'd53, 16'hFFFF);
        rd(6'd53, rv); check("R10 dout write ignored", 32'(rv), 32'h0081);
        wr(6'd60, 16'hFFFF);
        rd(6'd60, rv); check("R10 unmapped", 32'(rv), 0);

        // R8: level interrupt on element 0
        wr(6'd50, 16'h0020);
        #1 check("R8 irq level high", 32'(irq[1]), 1);
        pin_in[3] = 1'b0;
        #1 check("R8 irq follows low", 32'(irq[1]), 0);
        pin_in[3] = 1'b1;
        #1 check("R8 irq high again", 32'(irq[1]), 1);
        wr(6'd50, 16'h0000);
        #1 check("R8 irq disabled", 32'(irq[1]), 0);

        // R11: edge detector from elements 9 (delay) and 10
        wr(6'd9,  ecfg(1'b0, 4'b1010, 5'd0, 5'd12));
        wr(6'd10, ecfg(1'b1, 4'b0010, 5'd1, 5'd12));
        wr(6'd49, 16'h002A);
        #1 check("R11 idle", 32'(irq[0]), 0);
        @(negedge clk);
        pin_in[4] = 1'b1;
        #1 check("R11 pulse high", 32'(irq[0]), 1);
        @(posedge clk); #1 check("R11 pulse ends", 32'(irq[0]), 0);
        @(negedge clk);
        pin_in[4] = 1'b0;
        #1 check("R11 no fall pulse", 32'(irq[0]), 0);

        done = 1'b1;
        finish_run();
    end
endmodule